// File: doc/BRIEF.md
# UART Channel-Mode FIFO Datapath

This block holds the receive and transmit byte queues of a serial port and decides, under a 2-bit channel mode, where each byte goes. Bytes come from the line receiver, from processor writes to the data register, and from received line breaks. Bytes leave through the processor read port and through a pop interface that feeds the line transmitter. The mode selects the path:

- **Normal:** line bytes go to the receive queue and processor bytes go to the transmit queue.
- **Echo:** every line byte is copied into both queues.
- **Local loopback:** processor bytes go back into the receive queue.
- **Remote loopback:** line bytes go straight into the transmit queue.

A 9-bit control word gates each direction with a pair of bits, one that turns it on and one that turns it off. The same word holds two flush bits that clear themselves after they act. The block reports the fill level of each queue. It raises a one-cycle overrun pulse when a byte is dropped because its queue is full. It also tells the line receiver whether it can take a byte, based on the queues that the current mode would fill.

Top module: `uart_chmode_fifo`

## Requirements
- R1: After reset the control word reads 0x128, which leaves both directions off. Both counts are 0, `cpu_rdata` is 0 and `tx_out_valid` is low.
- R2: The control word uses bit 2 for receive on, bit 3 for receive off, bit 4 for transmit on and bit 5 for transmit off. A direction is enabled only when its on bit is 1 and its off bit is 0. While a direction is disabled, its pushes and pops are ignored and its count does not change.
- R3: With mode value 0 (normal), a line byte enters the receive queue and a processor write enters the transmit queue.
- R4: With mode value 1 (echo), a line byte enters both queues and a processor write is dropped. In this mode `line_rx_ready` is low whenever either queue is full.
- R5: With mode value 2 (local loopback), a processor write enters the receive queue and line bytes are dropped.
- R6: With mode value 3 (remote loopback), a line byte enters the transmit queue and a processor write is dropped.
- R7: Each queue holds DEPTH bytes (16 by default) in first-in first-out order, and its count port shows the number of bytes it holds.
- R8: A push into a full queue drops the byte. The queue's overrun output (`rx_ovr` or `tx_ovr`) is high for the one cycle after the clock edge at which the push was made.
- R9: Writing the control word with bit 0 set empties the receive queue, and writing it with bit 1 set empties the transmit queue. Bits 0 and 1 always read back as 0.
- R10: `cpu_rdata` is 0 when the receive queue is empty or the receive direction is disabled. Otherwise it shows the oldest byte.
- R11: A line break pushes one zero byte into the receive queue in any mode. For the receive queue it takes priority over a line or processor byte in the same cycle.
- R12: `line_rx_ready` depends on the mode. In mode 0 it is low only when the receive queue is full. In mode 3 it is low only when the transmit queue is full. In mode 2 it is always high. In mode 1 it follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word write value |
| ctl_q | output | 9 | Current control word |
| mode | input | 2 | Channel mode (0 normal, 1 echo, 2 local loop, 3 remote loop) |
| line_rx_valid | input | 1 | Line receiver presents a byte |
| line_rx_data | input | 8 | Received byte |
| line_break | input | 1 | Line break detected this cycle |
| line_rx_ready | output | 1 | Block can accept a line byte |
| cpu_dwr | input | 1 | Processor write of the data register |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_drd | input | 1 | Processor read of the data register (pops) |
| cpu_rdata | output | 8 | Oldest receive byte, or 0 |
| tx_out_ready | input | 1 | Line transmitter takes the head byte |
| tx_out_valid | output | 1 | Transmit queue has a byte and is enabled |
| tx_out_data | output | 8 | Head of the transmit queue |
| rx_count | output | $clog2(DEPTH+1) | Receive queue fill level |
| tx_count | output | $clog2(DEPTH+1) | Transmit queue fill level |
| rx_ovr | output | 1 | Receive overrun pulse |
| tx_ovr | output | 1 | Transmit overrun pulse |

## Verification
The assertions assume that every input has a known value from reset onward. They also assume that `mode` changes only while no line or processor byte is being offered, so the routing a byte sees is the one the mode showed at its edge. The bench drives all inputs at falling edges, holds each strobe for exactly one cycle, and changes the mode only between transfers. It never offers a line byte while `line_rx_ready` is low, except in the overrun cases, where a dropped byte is the point of the test.

// File: rtl/uart_chm_pkg.sv
package uart_chm_pkg;
  typedef enum logic [1:0] {
    CHM_NORMAL = 2'd0,
    CHM_ECHO   = 2'd1,
    CHM_LLOOP  = 2'd2,
    CHM_RLOOP  = 2'd3
  } chan_mode_e;

  localparam int CTL_W = 9;
  localparam logic [CTL_W-1:0] CTL_RST = 9'h128;
  localparam int B_RXFLUSH = 0;
  localparam int B_TXFLUSH = 1;
  localparam int B_RXON    = 2;
  localparam int B_RXOFF   = 3;
  localparam int B_TXON    = 4;
  localparam int B_TXOFF   = 5;
  localparam logic [CTL_W-1:0] CTL_SELFCLR = 9'h003;

  function automatic logic line_feeds_rx(chan_mode_e m);
    return (m == CHM_NORMAL) || (m == CHM_ECHO);
  endfunction

  function automatic logic line_feeds_tx(chan_mode_e m);
    return (m == CHM_RLOOP) || (m == CHM_ECHO);
  endfunction

  function automatic logic cpu_feeds_rx(chan_mode_e m);
    return m == CHM_LLOOP;
  endfunction

  function automatic logic cpu_feeds_tx(chan_mode_e m);
    return m == CHM_NORMAL;
  endfunction

  function automatic logic dir_on(logic on_bit, logic off_bit);
    return on_bit && !off_bit;
  endfunction
endpackage

// File: rtl/chm_byte_fifo.sv
module chm_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      drop  <= 1'b0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      drop  <= 1'b0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      drop  <= push && full;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R9
  AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(count)); // R8
endmodule

// File: rtl/chm_router.sv
module chm_router
  import uart_chm_pkg::*;
(
  input  chan_mode_e  mode,
  input  logic        rx_en,
  input  logic        tx_en,
  input  logic        line_valid,
  input  logic [7:0]  line_data,
  input  logic        line_brk,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_data,
  input  logic        rx_full,
  input  logic        tx_full,
  output logic        rx_push,
  output logic [7:0]  rx_pdata,
  output logic        tx_push,
  output logic [7:0]  tx_pdata,
  output logic        line_ready
);
  logic line_rx_hit, cpu_rx_hit;

  always_comb begin
    line_rx_hit = line_valid && line_feeds_rx(mode);
    cpu_rx_hit  = cpu_wr && cpu_feeds_rx(mode);

    rx_push  = rx_en && (line_brk || line_rx_hit || cpu_rx_hit);
    if (line_brk)        rx_pdata = 8'h00;
    else if (cpu_rx_hit) rx_pdata = cpu_data;
    else                 rx_pdata = line_data;

    tx_push  = tx_en && ((line_valid && line_feeds_tx(mode)) ||
                         (cpu_wr && cpu_feeds_tx(mode)));
    tx_pdata = cpu_feeds_tx(mode) ? cpu_data : line_data;

    line_ready = !((line_feeds_rx(mode) && rx_full) ||
                   (line_feeds_tx(mode) && tx_full));
  end
endmodule

// File: rtl/uart_chmode_fifo.sv
module uart_chmode_fifo
  import uart_chm_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_wr,
  input  logic [8:0]                 ctl_wdata,
  output logic [8:0]                 ctl_q,
  input  logic [1:0]                 mode,
  input  logic                       line_rx_valid,
  input  logic [7:0]                 line_rx_data,
  input  logic                       line_break,
  output logic                       line_rx_ready,
  input  logic                       cpu_dwr,
  input  logic [7:0]                 cpu_wdata,
  input  logic                       cpu_drd,
  output logic [7:0]                 cpu_rdata,
  input  logic                       tx_out_ready,
  output logic                       tx_out_valid,
  output logic [7:0]                 tx_out_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       rx_ovr,
  output logic                       tx_ovr
);
  logic       rx_en, tx_en, rx_flush, tx_flush;
  logic       rx_push, tx_push, rx_pop, tx_pop;
  logic [7:0] rx_pdata, tx_pdata, rx_head, tx_head;
  logic       rx_full, tx_full, rx_empty, tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_wr) ctl_q <= ctl_wdata & ~CTL_SELFCLR;
  end

  assign rx_flush = ctl_wr && ctl_wdata[B_RXFLUSH];
  assign tx_flush = ctl_wr && ctl_wdata[B_TXFLUSH];
  assign rx_en    = dir_on(ctl_q[B_RXON], ctl_q[B_RXOFF]);
  assign tx_en    = dir_on(ctl_q[B_TXON], ctl_q[B_TXOFF]);
  assign rx_pop   = cpu_drd && rx_en;
  assign tx_pop   = tx_out_ready && tx_en;

  chm_router u_route (
    .mode(chan_mode_e'(mode)), .rx_en(rx_en), .tx_en(tx_en),
    .line_valid(line_rx_valid), .line_data(line_rx_data), .line_brk(line_break),
    .cpu_wr(cpu_dwr), .cpu_data(cpu_wdata),
    .rx_full(rx_full), .tx_full(tx_full),
    .rx_push(rx_push), .rx_pdata(rx_pdata),
    .tx_push(tx_push), .tx_pdata(tx_pdata),
    .line_ready(line_rx_ready)
  );

  chm_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .pdata(rx_pdata),
    .pop(rx_pop), .head(rx_head), .count(rx_count), .full(rx_full),
    .empty(rx_empty), .drop(rx_ovr)
  );

  chm_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .pdata(tx_pdata),
    .pop(tx_pop), .head(tx_head), .count(tx_count), .full(tx_full),
    .empty(tx_empty), .drop(tx_ovr)
  );

  assign cpu_rdata    = (rx_en && !rx_empty) ? rx_head : 8'h00;
  assign tx_out_valid = tx_en && !tx_empty;
  assign tx_out_data  = tx_head;

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q[1:0] == 2'b00)); // R9
  AST_RX_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_flush) |=> $stable(rx_count)); // R2
  AST_TX_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_flush) |=> $stable(tx_count)); // R2
  AST_ECHO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && (rx_count == DEPTH || tx_count == DEPTH)) |-> !line_rx_ready); // R4
  AST_EMPTY_READ0: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == 0) |-> (cpu_rdata == 8'h00)); // R10
endmodule

// File: tb/sim_uart_chmode_fifo.sv
module sim_uart_chmode_fifo;
  localparam int D = 16;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0; logic [8:0] ctl_wdata = 0; logic [8:0] ctl_q;
  logic [1:0] mode = 0;
  logic line_rx_valid = 0, line_break = 0, line_rx_ready;
  logic [7:0] line_rx_data = 0;
  logic cpu_dwr = 0, cpu_drd = 0; logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic tx_out_ready = 0, tx_out_valid; logic [7:0] tx_out_data;
  logic [4:0] rx_count, tx_count;
  logic rx_ovr, tx_ovr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  uart_chmode_fifo #(.DEPTH(D)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [8:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask
  task automatic line_b(input logic [7:0] b);
    @(negedge clk); line_rx_valid = 1; line_rx_data = b;
    @(negedge clk); line_rx_valid = 0;
  endtask
  task automatic cpu_b(input logic [7:0] b);
    @(negedge clk); cpu_dwr = 1; cpu_wdata = b;
    @(negedge clk); cpu_dwr = 0;
  endtask
  task automatic brk();
    @(negedge clk); line_break = 1;
    @(negedge clk); line_break = 0;
  endtask
  task automatic rd(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(cpu_rdata == exp, tag, cpu_rdata, exp);
    cpu_drd = 1;
    @(negedge clk); cpu_drd = 0;
  endtask
  task automatic txp(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(tx_out_valid && tx_out_data == exp, tag, tx_out_data, exp);
    tx_out_ready = 1;
    @(negedge clk); tx_out_ready = 0;
  endtask

  initial begin
    string mtag [4] = '{"R3", "R4", "R5", "R6"};
    int er, et;
    bit all_ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_q == 9'h128, "R1 ctl", ctl_q, 9'h128);
    chk(rx_count == 0 && tx_count == 0, "R1 counts", {rx_count, tx_count}, 0);
    chk(cpu_rdata == 0 && !tx_out_valid, "R1 outputs", cpu_rdata, 0);
    // R2 disabled after reset
    line_b(8'h11); cpu_b(8'h22);
    chk(rx_count == 0 && tx_count == 0, "R2 off after reset", {rx_count, tx_count}, 0);
    wr_ctl(9'h03C); // both on bits set, but off bits set as well
    line_b(8'h11); cpu_b(8'h22);
    chk(rx_count == 0 && tx_count == 0, "R2 off bit wins", {rx_count, tx_count}, 0);
    wr_ctl(9'h014);
    // mode sweep
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      wr_ctl(9'h017);
      line_b(8'h40 + 8'(m));
      cpu_b(8'h80 + 8'(m));
      er = ((m == 0 || m == 1) ? 1 : 0) + (m == 2 ? 1 : 0);
      et = ((m == 1 || m == 3) ? 1 : 0) + (m == 0 ? 1 : 0);
      chk(rx_count == 5'(er), mtag[m], rx_count, er);
      chk(tx_count == 5'(et), mtag[m], tx_count, et);
      if (m <= 1) rd(8'h40 + 8'(m), mtag[m]);
      else if (m == 2) rd(8'h80 + 8'(m), mtag[m]);
      if (m == 0) txp(8'h80, mtag[m]);
      else if (m != 2) txp(8'h40 + 8'(m), mtag[m]);
    end
    // R7 R8 R12 receive fill and overrun, normal mode
    mode = 0; wr_ctl(9'h017);
    for (int i = 0; i < D; i++) line_b(8'(i * 7 + 3));
    chk(rx_count == 5'(D), "R7 full count", rx_count, D);
    chk(!line_rx_ready, "R12 normal rx full", line_rx_ready, 0);
    line_b(8'hEE);
    chk(rx_ovr == 1, "R8 rx overrun pulse", rx_ovr, 1);
    @(negedge clk);
    chk(rx_ovr == 0 && rx_count == 5'(D), "R8 pulse ends, count kept", rx_count, D);
    all_ok = 1;
    for (int i = 0; i < D; i++) begin
      if (cpu_rdata != 8'(i * 7 + 3)) all_ok = 0;
      rd(8'(i * 7 + 3), "R7 order");
    end
    chk(all_ok, "R7 order sweep", all_ok, 1);
    rd(8'h00, "R10 empty read");
    // R8 transmit overrun and R4 R12 ready by mode
    for (int i = 0; i < D; i++) cpu_b(8'(i));
    cpu_b(8'hFF);
    chk(tx_ovr == 1, "R8 tx overrun pulse", tx_ovr, 1);
    chk(line_rx_ready == 1, "R12 normal tx full ready", line_rx_ready, 1);
    mode = 1; @(negedge clk);
    chk(!line_rx_ready, "R4 echo tx full", line_rx_ready, 0);
    mode = 3; @(negedge clk);
    chk(!line_rx_ready, "R12 remote tx full", line_rx_ready, 0);
    mode = 2; @(negedge clk);
    chk(line_rx_ready == 1, "R12 local always ready", line_rx_ready, 1);
    // R9 flush with self clear
    wr_ctl(9'h016);
    chk(ctl_q == 9'h014, "R9 self clear", ctl_q, 9'h014);
    chk(tx_count == 0, "R9 tx flush", tx_count, 0);
    // R11 break in local loopback
    cpu_b(8'h55); brk();
    chk(rx_count == 2, "R11 break count", rx_count, 2);
    rd(8'h55, "R11 first");
    rd(8'h00, "R11 zero byte");
    chk(rx_count == 0, "R11 drained", rx_count, 0);
    // R2 R10 pop ignored while receive is off
    cpu_b(8'h66);
    wr_ctl(9'h01C);
    chk(cpu_rdata == 0, "R10 disabled read", cpu_rdata, 0);
    @(negedge clk); cpu_drd = 1; @(negedge clk); cpu_drd = 0;
    wr_ctl(9'h014);
    chk(rx_count == 1 && cpu_rdata == 8'h66, "R2 pop ignored", cpu_rdata, 8'h66);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule